// File: doc/BRIEF.md
# Indirect Transfer Progress Tracker

This block follows the progress of indirect transfers between a serial flash and a local buffer SRAM. It has one channel for flash-to-buffer transfers (read) and one for buffer-to-flash transfers (write). Software programs a start address and a byte length for a channel, then issues a start command. The channel counts down on every byte-moved pulse from the flash side. When the count reaches zero it raises a sticky done flag. Software can abort a transfer at any moment with a cancel command, which drops the transfer without marking it done.

In parallel, the block keeps the word fill level of each half of the buffer SRAM. The levels follow push and pop pulses from the storage side. The read half raises a watermark event when its byte equivalent reaches a programmed threshold, and a full event when it reaches the partition depth. A pop from an empty write half raises an underflow event. All events collect in a write-1-to-clear status register. A mask register selects which status bits drive the interrupt line.

Software reaches the block through a simple register port. Writes take effect on the clock edge. Reads are combinational from the address.

Top module: `xfer_tracker`

## Requirements
- R1: After reset, every status bit, the mask, both fill levels, both remaining counts, and the busy and done flags read 0, and `irq` is low.
- R2: A start with a programmed length N>0 sets busy (control bit 2) and loads N as the remaining count, which reads at the channel's length offset (read channel 0x08, write channel 0x18). Each byte-moved pulse while busy decrements the count. Byte-moved pulses while idle change nothing.
- R3: The byte pulse that takes the remaining count from 1 to 0 clears busy, sets done (control bit 5) and sets status bit 2 (transfer complete), all on that same edge.
- R4: A start with a programmed length of 0 sets done and status bit 2 at once, without ever setting busy.
- R5: A start while the channel is busy leaves its remaining count and busy flag unchanged, and sets status bit 3 (start rejected).
- R6: Cancel (control bit 1) clears busy and the remaining count in one cycle. It sets neither done nor status bit 2. Cancel has priority over a start in the same write.
- R7: Writing 1 to control bit 5 clears done. An accepted start also clears done.
- R8: The level register (0x28) holds the read-half fill level in words in bits 15:0 and the write-half level in bits 31:16. A push adds 1 and a pop subtracts 1. A push at the partition depth (half the SRAM words) and a pop at 0 leave the level unchanged. A push and a pop in the same cycle leave it unchanged.
- R9: Status bit 6 (watermark) is set on the edge where the read level times the word width in bytes first reaches or exceeds the watermark at 0x0C. It is not set again until that product has dropped below the watermark. A watermark of 0 never sets it.
- R10: Status bit 12 (buffer full) is set on the edge where the read level reaches the partition depth. It is not set while the level merely stays there.
- R11: A write-half pop at level 0, with no push in the same cycle, sets status bit 1 (underflow).
- R12: Writing 1s to the status register (0x20) clears those bits. A bit set by an event in the same cycle stays set. `irq` is high exactly when some status bit is also set in the mask at 0x24.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| rd_byte_moved | input | 1 | One byte moved from the flash into the read half |
| wr_byte_moved | input | 1 | One byte moved from the write half to the flash |
| rd_word_push | input | 1 | Word written into the read half |
| rd_word_pop | input | 1 | Word taken out of the read half |
| wr_word_push | input | 1 | Word written into the write half |
| wr_word_pop | input | 1 | Word taken out of the write half |
| irq | output | 1 | Interrupt, OR of masked status bits |

## Verification
The bench builds the block with a 16-word SRAM, which gives an 8-word partition, and with 4-byte words. At that depth a few pushes reach the buffer-full edge and the saturation at the partition depth. A watermark of 12 bytes falls inside that range, so the bench can cross it, fall back below it and cross it again. The 16-bit length parameter is kept, so short transfers of 0, 2, 5 and 10 bytes cover the zero-length, reject, cancel and last-byte cases.

// File: rtl/xfer_trk_pkg.sv
package xfer_trk_pkg;
    localparam int REG_AW = 8;
    localparam int REG_DW = 32;

    // channel register block: read channel at 0x00, write channel at 0x10
    localparam logic [REG_AW-1:0] OFS_CH_STRIDE = 8'h10;
    localparam logic [REG_AW-1:0] OFS_CTRL      = 8'h00;
    localparam logic [REG_AW-1:0] OFS_SADDR     = 8'h04;
    localparam logic [REG_AW-1:0] OFS_LEN       = 8'h08;
    localparam logic [REG_AW-1:0] OFS_WMARK     = 8'h0C;
    localparam logic [REG_AW-1:0] OFS_STATUS    = 8'h20;
    localparam logic [REG_AW-1:0] OFS_MASK      = 8'h24;
    localparam logic [REG_AW-1:0] OFS_LEVEL     = 8'h28;

    // control bit positions
    localparam int CTL_START  = 0;
    localparam int CTL_CANCEL = 1;
    localparam int CTL_BUSY   = 2;
    localparam int CTL_DONE   = 5;

    // status bit positions
    localparam int ST_W        = 13;
    localparam int ST_UNDER    = 1;
    localparam int ST_COMPLETE = 2;
    localparam int ST_REJECT   = 3;
    localparam int ST_WMARK    = 6;
    localparam int ST_FULL     = 12;
endpackage

// File: rtl/xfer_chan.sv
module xfer_chan #(
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              len_we,
    input  logic [CNT_W-1:0]  len_wdata,
    input  logic              saddr_we,
    input  logic [ADDR_W-1:0] saddr_wdata,
    input  logic              start,
    input  logic              cancel,
    input  logic              done_clr,
    input  logic              byte_moved,
    output logic              busy,
    output logic              done,
    output logic [CNT_W-1:0]  remain,
    output logic [ADDR_W-1:0] saddr,
    output logic              evt_complete,
    output logic              evt_reject
);
    typedef struct packed {
        logic              busy;
        logic              done;
        logic [CNT_W-1:0]  remain;
        logic [CNT_W-1:0]  len;
        logic [ADDR_W-1:0] saddr;
    } chan_t;

    chan_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        evt_complete = 1'b0;
        evt_reject   = 1'b0;
        if (len_we)   st_d.len   = len_wdata;
        if (saddr_we) st_d.saddr = saddr_wdata;
        if (done_clr) st_d.done  = 1'b0;
        if (cancel) begin
            st_d.busy   = 1'b0;
            st_d.remain = '0;
        end else begin
            if (start) begin
                if (st_q.busy) begin
                    evt_reject = 1'b1;
                end else if (st_q.len == '0) begin
                    st_d.done    = 1'b1;
                    st_d.remain  = '0;
                    evt_complete = 1'b1;
                end else begin
                    st_d.done   = 1'b0;
                    st_d.busy   = 1'b1;
                    st_d.remain = st_q.len;
                end
            end
            if (st_q.busy && byte_moved) begin
                st_d.remain = st_q.remain - 1'b1;
                if (st_q.remain == CNT_W'(1)) begin
                    st_d.busy    = 1'b0;
                    st_d.done    = 1'b1;
                    evt_complete = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy   = st_q.busy;
    assign done   = st_q.done;
    assign remain = st_q.remain;
    assign saddr  = st_q.saddr;

    assert_busy_has_bytes_R2: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (remain != '0));
    assert_last_byte_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && byte_moved && !cancel && remain == CNT_W'(1)) |=> (done && !busy));
    assert_reject_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (start && busy && !cancel && !byte_moved) |=> ($stable(remain) && busy));
    assert_cancel_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cancel |=> (!busy && remain == '0));
    assert_cancel_no_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cancel && !done) |=> !done);
endmodule

// File: rtl/xfer_fill.sv
module xfer_fill #(
    parameter int  PART_WORDS = 32,
    parameter int  WORD_BYTES = 4,
    parameter int  LVL_W      = 6,
    parameter bit  IS_READ    = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic [31:0]      wmark,
    output logic [LVL_W-1:0] level,
    output logic             evt_wmark,
    output logic             evt_full,
    output logic             evt_under
);
    localparam logic [LVL_W-1:0] TOP = LVL_W'(PART_WORDS);

    typedef struct packed {
        logic [LVL_W-1:0] level;
        logic             above;
    } fill_t;

    fill_t st_d, st_q;
    logic  pop_empty;

    always_comb begin
        st_d      = st_q;
        pop_empty = pop && !push && (st_q.level == '0);
        if (push && !pop && st_q.level != TOP)
            st_d.level = st_q.level + 1'b1;
        else if (pop && !push && st_q.level != '0)
            st_d.level = st_q.level - 1'b1;
    end

    generate
        if (IS_READ) begin : g_rd
            logic above_now;
            always_comb begin
                above_now = (wmark != 32'd0) &&
                            (32'(st_d.level) * 32'(WORD_BYTES) >= wmark);
                evt_wmark = above_now && !st_q.above;
                evt_full  = (st_d.level == TOP) && (st_q.level != TOP);
                evt_under = 1'b0;
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) st_q <= '0;
                else        st_q <= '{level: st_d.level, above: above_now};
            end
        end else begin : g_wr
            always_comb begin
                evt_wmark = 1'b0;
                evt_full  = 1'b0;
                evt_under = pop_empty;
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) st_q <= '0;
                else        st_q <= '{level: st_d.level, above: 1'b0};
            end
        end
    endgenerate

    assign level = st_q.level;

    assert_level_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        level <= TOP);
    assert_pushpop_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop) |=> $stable(level));
    assert_full_edge_R10: assert property (@(posedge clk) disable iff (!rst_n)
        evt_full |=> (level == TOP));
    assert_under_empty_R11: assert property (@(posedge clk) disable iff (!rst_n)
        evt_under |-> (level == '0));
endmodule

// File: rtl/xfer_irq.sv
module xfer_irq #(
    parameter int ST_W = 13
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [ST_W-1:0] set_vec,
    input  logic            clr_we,
    input  logic [ST_W-1:0] clr_vec,
    input  logic            mask_we,
    input  logic [ST_W-1:0] mask_wdata,
    output logic [ST_W-1:0] status,
    output logic [ST_W-1:0] mask,
    output logic            irq
);
    typedef struct packed {
        logic [ST_W-1:0] status;
        logic [ST_W-1:0] mask;
    } irq_t;

    irq_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_we)  st_d.status = st_q.status & ~clr_vec;
        st_d.status = st_d.status | set_vec;
        if (mask_we) st_d.mask = mask_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status = st_q.status;
    assign mask   = st_q.mask;
    assign irq    = |(st_q.status & st_q.mask);

    assert_set_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_vec) |=> (|status));
    assert_clear_all_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && (&clr_vec) && set_vec == '0) |=> (status == '0));
endmodule

// File: rtl/xfer_tracker.sv
module xfer_tracker #(
    parameter int SRAM_WORDS = 64,
    parameter int WORD_BYTES = 4,
    parameter int CNT_W      = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [7:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        rd_byte_moved,
    input  logic        wr_byte_moved,
    input  logic        rd_word_push,
    input  logic        rd_word_pop,
    input  logic        wr_word_push,
    input  logic        wr_word_pop,
    output logic        irq
);
    import xfer_trk_pkg::*;

    localparam int PART_WORDS = SRAM_WORDS / 2;
    localparam int LVL_W      = $clog2(PART_WORDS + 1);
    localparam int N_CH       = 2;

    logic [N_CH-1:0]  ch_busy, ch_done, ch_cmpl, ch_rej, ch_byte;
    logic [CNT_W-1:0] ch_remain [N_CH];
    logic [31:0]      ch_saddr  [N_CH];

    logic [31:0]      wmark_q;
    logic [LVL_W-1:0] rd_level, wr_level;
    logic             rd_wm_evt, rd_full_evt, rd_under_evt;
    logic             wr_wm_evt, wr_full_evt, wr_under_evt;
    logic [ST_W-1:0]  set_vec, status, mask;

    assign ch_byte = {wr_byte_moved, rd_byte_moved};

    generate
        for (genvar g = 0; g < N_CH; g++) begin : g_ch
            localparam logic [7:0] BASE = 8'(g) * OFS_CH_STRIDE;
            logic ctl_wr;
            assign ctl_wr = reg_we && (reg_addr == BASE + OFS_CTRL);
            xfer_chan #(.CNT_W(CNT_W), .ADDR_W(32)) i_chan (
                .clk          (clk),
                .rst_n        (rst_n),
                .len_we       (reg_we && (reg_addr == BASE + OFS_LEN)),
                .len_wdata    (reg_wdata[CNT_W-1:0]),
                .saddr_we     (reg_we && (reg_addr == BASE + OFS_SADDR)),
                .saddr_wdata  (reg_wdata),
                .start        (ctl_wr && reg_wdata[CTL_START]),
                .cancel       (ctl_wr && reg_wdata[CTL_CANCEL]),
                .done_clr     (ctl_wr && reg_wdata[CTL_DONE]),
                .byte_moved   (ch_byte[g]),
                .busy         (ch_busy[g]),
                .done         (ch_done[g]),
                .remain       (ch_remain[g]),
                .saddr        (ch_saddr[g]),
                .evt_complete (ch_cmpl[g]),
                .evt_reject   (ch_rej[g])
            );
        end
    endgenerate

    // watermark register, two-process
    logic [31:0] wmark_d;
    always_comb begin
        wmark_d = wmark_q;
        if (reg_we && reg_addr == OFS_WMARK) wmark_d = reg_wdata;
    end
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wmark_q <= '0;
        else        wmark_q <= wmark_d;
    end

    xfer_fill #(.PART_WORDS(PART_WORDS), .WORD_BYTES(WORD_BYTES), .LVL_W(LVL_W),
                .IS_READ(1'b1)) i_rd_fill (
        .clk(clk), .rst_n(rst_n), .push(rd_word_push), .pop(rd_word_pop),
        .wmark(wmark_q), .level(rd_level), .evt_wmark(rd_wm_evt),
        .evt_full(rd_full_evt), .evt_under(rd_under_evt)
    );

    xfer_fill #(.PART_WORDS(PART_WORDS), .WORD_BYTES(WORD_BYTES), .LVL_W(LVL_W),
                .IS_READ(1'b0)) i_wr_fill (
        .clk(clk), .rst_n(rst_n), .push(wr_word_push), .pop(wr_word_pop),
        .wmark(wmark_q), .level(wr_level), .evt_wmark(wr_wm_evt),
        .evt_full(wr_full_evt), .evt_under(wr_under_evt)
    );

    always_comb begin
        set_vec              = '0;
        set_vec[ST_UNDER]    = wr_under_evt | rd_under_evt;
        set_vec[ST_COMPLETE] = |ch_cmpl;
        set_vec[ST_REJECT]   = |ch_rej;
        set_vec[ST_WMARK]    = rd_wm_evt | wr_wm_evt;
        set_vec[ST_FULL]     = rd_full_evt | wr_full_evt;
    end

    xfer_irq #(.ST_W(ST_W)) i_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_vec    (set_vec),
        .clr_we     (reg_we && reg_addr == OFS_STATUS),
        .clr_vec    (reg_wdata[ST_W-1:0]),
        .mask_we    (reg_we && reg_addr == OFS_MASK),
        .mask_wdata (reg_wdata[ST_W-1:0]),
        .status     (status),
        .mask       (mask),
        .irq        (irq)
    );

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_CTRL: begin
                reg_rdata[CTL_BUSY] = ch_busy[0];
                reg_rdata[CTL_DONE] = ch_done[0];
            end
            OFS_CH_STRIDE + OFS_CTRL: begin
                reg_rdata[CTL_BUSY] = ch_busy[1];
                reg_rdata[CTL_DONE] = ch_done[1];
            end
            OFS_SADDR:                 reg_rdata = ch_saddr[0];
            OFS_CH_STRIDE + OFS_SADDR: reg_rdata = ch_saddr[1];
            OFS_LEN:                   reg_rdata = 32'(ch_remain[0]);
            OFS_CH_STRIDE + OFS_LEN:   reg_rdata = 32'(ch_remain[1]);
            OFS_WMARK:                 reg_rdata = wmark_q;
            OFS_STATUS:                reg_rdata = 32'(status);
            OFS_MASK:                  reg_rdata = 32'(mask);
            OFS_LEVEL:                 reg_rdata = {16'(wr_level), 16'(rd_level)};
            default:                   reg_rdata = '0;
        endcase
    end

    assert_irq_follows_mask_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |-> !irq);
    assert_wmark_edge_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wmark_q == 32'd0 && !(reg_we && reg_addr == OFS_WMARK)) |=> !rd_wm_evt);
endmodule

// File: tb/test_xfer_tracker.sv
module test_xfer_tracker;
    localparam int CLK_PERIOD = 10;
    localparam int SRAM_WORDS = 16;
    localparam int WORD_BYTES = 4;
    localparam int PART       = SRAM_WORDS / 2;

    localparam logic [7:0] A_RCTL = 8'h00, A_RSAD = 8'h04, A_RLEN = 8'h08, A_WM = 8'h0C;
    localparam logic [7:0] A_WCTL = 8'h10, A_WLEN = 8'h18;
    localparam logic [7:0] A_ST = 8'h20, A_MSK = 8'h24, A_LVL = 8'h28;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        rd_byte_moved = 1'b0, wr_byte_moved = 1'b0;
    logic        rd_word_push = 1'b0, rd_word_pop = 1'b0;
    logic        wr_word_push = 1'b0, wr_word_pop = 1'b0;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xfer_tracker #(.SRAM_WORDS(SRAM_WORDS), .WORD_BYTES(WORD_BYTES), .CNT_W(16)) i_xfer_tracker (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .rd_byte_moved(rd_byte_moved), .wr_byte_moved(wr_byte_moved),
        .rd_word_push(rd_word_push), .rd_word_pop(rd_word_pop),
        .wr_word_push(wr_word_push), .wr_word_pop(wr_word_pop), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic chk_reg(input string req, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        check(req, v, exp);
    endtask

    // one-cycle pulses: sel 0 rd_byte, 1 wr_byte, 2 rd_push, 3 rd_pop, 4 wr_push, 5 wr_pop, 6 wr push+pop
    task automatic pulse(input int sel, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            case (sel)
                0: rd_byte_moved = 1'b1;
                1: wr_byte_moved = 1'b1;
                2: rd_word_push = 1'b1;
                3: rd_word_pop = 1'b1;
                4: wr_word_push = 1'b1;
                5: wr_word_pop = 1'b1;
                default: begin wr_word_push = 1'b1; wr_word_pop = 1'b1; end
            endcase
            @(negedge clk);
            {rd_byte_moved, wr_byte_moved, rd_word_push, rd_word_pop, wr_word_push, wr_word_pop} = '0;
        end
    endtask

    task automatic t_reset;
        chk_reg("R1 status", A_ST, 0);
        chk_reg("R1 mask", A_MSK, 0);
        chk_reg("R1 level", A_LVL, 0);
        chk_reg("R1 rd ctrl", A_RCTL, 0);
        chk_reg("R1 rd len", A_RLEN, 0);
        check("R1 irq", 32'(irq), 0);
    endtask

    task automatic t_read_xfer;
        pulse(0, 2);
        chk_reg("R2 idle byte pulses ignored", A_RLEN, 0);
        wr(A_RSAD, 32'h0001_2340);
        chk_reg("R2 start address kept", A_RSAD, 32'h0001_2340);
        wr(A_RLEN, 5);
        wr(A_RCTL, 32'h1);
        chk_reg("R2 busy after start", A_RCTL, 32'h4);
        chk_reg("R2 remaining loaded", A_RLEN, 5);
        pulse(0, 3);
        chk_reg("R2 remaining after 3 bytes", A_RLEN, 2);
        wr(A_RCTL, 32'h1);
        chk_reg("R5 start while busy keeps count", A_RLEN, 2);
        chk_reg("R5 reject status bit 3", A_ST, 32'h8);
        wr(A_ST, 32'h8);
        pulse(0, 1);
        chk_reg("R3 not done at count 1", A_RCTL, 32'h4);
        chk_reg("R3 no complete early", A_ST, 0);
        pulse(0, 1);
        chk_reg("R3 done and idle", A_RCTL, 32'h20);
        chk_reg("R3 complete status bit 2", A_ST, 32'h4);
        check("R12 irq low with mask 0", 32'(irq), 0);
        wr(A_MSK, 32'h4);
        check("R12 irq high when masked bit set", 32'(irq), 1);
        wr(A_ST, 32'h4);
        check("R12 irq low after clear", 32'(irq), 0);
        chk_reg("R12 status cleared", A_ST, 0);
        wr(A_RCTL, 32'h20);
        chk_reg("R7 done cleared by bit 5", A_RCTL, 0);
    endtask

    task automatic t_zero_len;
        wr(A_RLEN, 0);
        wr(A_RCTL, 32'h1);
        chk_reg("R4 zero length done no busy", A_RCTL, 32'h20);
        chk_reg("R4 zero length complete", A_ST, 32'h4);
        wr(A_ST, 32'hFFFF);
        wr(A_RLEN, 3);
        wr(A_RCTL, 32'h1);
        chk_reg("R7 accepted start clears done", A_RCTL, 32'h4);
    endtask

    task automatic t_cancel;
        wr(A_RCTL, 32'h2);
        chk_reg("R6 cancel clears count", A_RLEN, 0);
        chk_reg("R6 cancel idle not done", A_RCTL, 0);
        chk_reg("R6 cancel no complete", A_ST, 0);
        wr(A_RLEN, 10);
        wr(A_RCTL, 32'h3);
        chk_reg("R6 cancel beats start", A_RCTL, 0);
        chk_reg("R6 cancel beats start count", A_RLEN, 0);
    endtask

    task automatic t_write_chan;
        wr(A_WLEN, 2);
        wr(A_WCTL, 32'h1);
        chk_reg("R2 write channel busy", A_WCTL, 32'h4);
        pulse(0, 1);
        chk_reg("R2 read bytes leave write count", A_WLEN, 2);
        pulse(1, 2);
        chk_reg("R3 write channel done", A_WCTL, 32'h20);
        chk_reg("R3 write channel complete", A_ST, 32'h4);
        wr(A_ST, 32'hFFFF);
    endtask

    task automatic t_read_level;
        wr(A_WM, 12);
        pulse(2, 2);
        chk_reg("R9 below watermark", A_ST, 0);
        chk_reg("R8 read level 2", A_LVL, 2);
        pulse(2, 1);
        chk_reg("R9 watermark reached", A_ST, 32'h40);
        wr(A_ST, 32'h40);
        pulse(2, 1);
        pulse(3, 1);
        chk_reg("R9 no repeat while above", A_ST, 0);
        pulse(3, 1);
        pulse(2, 1);
        chk_reg("R9 re-arm after dropping below", A_ST, 32'h40);
        wr(A_ST, 32'hFFFF);
        pulse(2, PART - 3);
        chk_reg("R10 full at partition depth", A_ST, 32'h1000);
        wr(A_ST, 32'hFFFF);
        pulse(2, 1);
        chk_reg("R8 saturate at depth", A_LVL, PART);
        chk_reg("R10 not set again while full", A_ST, 0);
        pulse(3, PART + 1);
        chk_reg("R8 read level floor 0", A_LVL, 0);
        chk_reg("R11 read pop at empty no underflow", A_ST, 0);
        wr(A_WM, 0);
        pulse(2, 1);
        chk_reg("R9 watermark 0 disabled", A_ST, 0);
        pulse(3, 1);
    endtask

    task automatic t_write_level;
        pulse(4, 2);
        chk_reg("R8 write level in high half", A_LVL, 32'h0002_0000);
        pulse(6, 1);
        chk_reg("R8 push and pop hold level", A_LVL, 32'h0002_0000);
        pulse(5, 2);
        chk_reg("R11 no underflow down to 0", A_ST, 0);
        pulse(5, 1);
        chk_reg("R11 underflow on empty pop", A_ST, 32'h2);
        chk_reg("R8 write level stays 0", A_LVL, 0);
        wr(A_MSK, 32'h1000);
        check("R12 unmasked bit gives no irq", 32'(irq), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_read_xfer();
        t_zero_len();
        t_cancel();
        t_write_chan();
        t_read_level();
        t_write_level();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule